// File: doc/BRIEF.md
# Debug Trigger Chaining Resolver

This block sits at the end of a debug trigger path. Address and data comparators elsewhere in the core produce one raw hit bit per trigger for the instruction being evaluated. The resolver combines those hits with the per-trigger configuration it holds. It decides whether a debug trap must be taken before the current instruction completes or after it, that is, at the next instruction. It also reports which trigger caused the trap.

The triggers are grouped in fixed pairs, and each pair has a fixed kind: fetch, store or load. A pair can be chained, so that it acts only when both of its halves hit together and agree on timing. The configuration is loaded through a CSR update port that accepts one write per cycle. Each trigger has its own configuration word, and one further word holds the chain bits for all the pairs. The trap outputs are combinational in the current hits and the registered configuration.

Top module: `dtr_trigger_chain_resolver`

## Requirements
- R1: After reset every trigger is disabled, unchained, has timing 0 and selects address match. With any hit pattern, trap_now and trap_next stay 0 and fire_idx is 0.
- R2: An enabled, unchained trigger fires whenever its selected hit is 1. A disabled trigger never fires and never completes a chain.
- R3: For a chained pair (triggers 2g and 2g+1, chain bit g of the chain word), either both triggers fire or neither does. Both fire only when both are enabled and both selected hits are 1 in the same cycle.
- R4: A chained pair whose two triggers have different timing bits never fires, even when both hit.
- R5: A firing trigger with timing bit 0 raises trap_now, and one with timing bit 1 raises trap_next. Both flags are 1 when firing triggers of both timings are present.
- R6: fire_idx is the lowest-numbered firing trigger, and it is 0 when no trigger fires.
- R7: The pair kinds are fixed: group 0 (fetch, fetch), group 1 (store, store), group 2 (load, load), group 3 (fetch, store) and group 4 (fetch, load). Chain bit 1 of the store-store pair always reads as 0, so triggers 2 and 3 stay independent whatever is written.
- R8: Config word bit 2 selects data_hit instead of addr_hit. Load-kind triggers (4, 5 and 9) ignore that bit and always use addr_hit.
- R9: A CSR write to address 0x7A0+k loads trigger k's word: bit 0 is enable, bit 1 is timing, bit 2 is data select. A write to 0x7B0 loads the chain bits from data[4:0]. A write changes the outputs only from the cycle after the write edge. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wen | input | 1 | CSR update valid, one per cycle |
| csr_addr | input | CSR_AW (12) | CSR update address |
| csr_wdata | input | XLEN (64) | CSR update data |
| addr_hit | input | 2*NUM_GROUPS (10) | Raw address-match results, one per trigger |
| data_hit | input | 2*NUM_GROUPS (10) | Raw data-match results, one per trigger |
| trap_now | output | 1 | Trap before the current instruction |
| trap_next | output | 1 | Trap at the next instruction |
| fire_idx | output | $clog2(2*NUM_GROUPS) (4) | Lowest firing trigger index |

## Verification
The bench builds the block with its defaults: five groups (ten triggers), a 12-bit CSR address and a 64-bit data word. With these values all five pair kinds are present. That covers the store-store pair whose chain bit is suppressed, the load triggers that refuse data selection, and the mixed fetch-store and fetch-load pairs. The unmapped addresses just past the trigger window and the upper data bits are both reachable, so ignored writes and ignored fields can be exercised.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_STORE = 2'd1,
    KIND_LOAD  = 2'd2
  } trig_kind_e;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_TIM_BIT  = 1;
  localparam int CFG_DATA_BIT = 2;
  localparam int KIND_PERIOD  = 5;

  typedef struct packed {
    logic data_sel;
    logic timing;
    logic enable;
  } trig_cfg_t;

  // Fixed kind of trigger k, repeating every five pairs.
  function automatic trig_kind_e trig_kind(input int k);
    int grp;
    int half;
    grp  = (k / 2) % KIND_PERIOD;
    half = k % 2;
    case (grp)
      0:       return KIND_FETCH;
      1:       return KIND_STORE;
      2:       return KIND_LOAD;
      3:       return (half == 1) ? KIND_STORE : KIND_FETCH;
      default: return (half == 1) ? KIND_LOAD : KIND_FETCH;
    endcase
  endfunction

  // Store paired with store cannot be chained.
  function automatic logic chain_legal(input int g);
    return !((trig_kind(2 * g) == KIND_STORE) && (trig_kind(2 * g + 1) == KIND_STORE));
  endfunction

  // Turn a written word into a config; loads refuse data selection.
  function automatic trig_cfg_t decode_cfg(input logic [2:0] bits, input trig_kind_e kind);
    trig_cfg_t c;
    c.enable   = bits[CFG_EN_BIT];
    c.timing   = bits[CFG_TIM_BIT];
    c.data_sel = bits[CFG_DATA_BIT] && (kind != KIND_LOAD);
    return c;
  endfunction

  // Hit after enable and source selection.
  function automatic logic effective_hit(input trig_cfg_t c, input logic a_hit, input logic d_hit);
    return c.enable && (c.data_sel ? d_hit : a_hit);
  endfunction

endpackage

// File: rtl/dtr_cfg_regs.sv
module dtr_cfg_regs
  import dtr_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int XLEN       = 64,
  parameter int CSR_AW     = 12,
  parameter int CFG_BASE   = 12'h7A0,
  parameter int CHAIN_ADDR = 12'h7B0,
  localparam int TRIG_N    = 2 * NUM_GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wen,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [TRIG_N-1:0] en_q,
  output logic [TRIG_N-1:0] tim_q,
  output logic [TRIG_N-1:0] dsel_q,
  output logic [NUM_GROUPS-1:0] chain_q
);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^csr_wdata[XLEN-1:3];

  logic chain_sel;
  assign chain_sel = csr_wen && (csr_addr == CSR_AW'(CHAIN_ADDR));

  for (genvar k = 0; k < TRIG_N; k++) begin : g_trig
    localparam trig_kind_e KIND = trig_kind(k);
    trig_cfg_t cfg_r;
    logic      sel;
    assign sel = csr_wen && (csr_addr == CSR_AW'(CFG_BASE + k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r <= '0;
      end else if (sel) begin
        cfg_r <= decode_cfg(csr_wdata[2:0], KIND);
      end
    end

    assign en_q[k]   = cfg_r.enable;
    assign tim_q[k]  = cfg_r.timing;
    assign dsel_q[k] = cfg_r.data_sel;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chain
    if (chain_legal(g)) begin : g_legal
      logic bit_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_r <= 1'b0;
        end else if (chain_sel) begin
          bit_r <= csr_wdata[g];
        end
      end
      assign chain_q[g] = bit_r;
    end else begin : g_forced
      assign chain_q[g] = 1'b0;
    end
  end

endmodule

// File: rtl/dtr_pair_resolve.sv
module dtr_pair_resolve
  import dtr_pkg::*;
(
  input  logic [1:0] en,
  input  logic [1:0] tim,
  input  logic [1:0] dsel,
  input  logic [1:0] addr_hit,
  input  logic [1:0] data_hit,
  input  logic       chain,
  output logic [1:0] eff_hit,
  output logic [1:0] fire
);

  trig_cfg_t cfg_lo;
  trig_cfg_t cfg_hi;
  logic      pair_ok;

  always_comb begin
    cfg_lo = '{data_sel: dsel[0], timing: tim[0], enable: en[0]};
    cfg_hi = '{data_sel: dsel[1], timing: tim[1], enable: en[1]};
    eff_hit[0] = effective_hit(cfg_lo, addr_hit[0], data_hit[0]);
    eff_hit[1] = effective_hit(cfg_hi, addr_hit[1], data_hit[1]);
    pair_ok    = eff_hit[0] && eff_hit[1] && (tim[0] == tim[1]);
    if (chain) begin
      fire = {pair_ok, pair_ok};
    end else begin
      fire = eff_hit;
    end
  end

endmodule

// File: rtl/dtr_fire_select.sv
module dtr_fire_select #(
  parameter int TRIG_N = 10,
  localparam int IDX_W = $clog2(TRIG_N)
) (
  input  logic [TRIG_N-1:0] fire_vec,
  input  logic [TRIG_N-1:0] tim,
  output logic              trap_now,
  output logic              trap_next,
  output logic [IDX_W-1:0]  fire_idx
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [TRIG_N-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = TRIG_N - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  always_comb begin
    trap_now  = |(fire_vec & ~tim);
    trap_next = |(fire_vec & tim);
    fire_idx  = lowest_set(fire_vec);
  end

endmodule

// File: rtl/dtr_trigger_chain_resolver.sv
module dtr_trigger_chain_resolver
  import dtr_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int XLEN       = 64,
  parameter int CSR_AW     = 12,
  parameter int CFG_BASE   = 12'h7A0,
  parameter int CHAIN_ADDR = 12'h7B0,
  localparam int TRIG_N    = 2 * NUM_GROUPS,
  localparam int IDX_W     = $clog2(TRIG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wen,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [TRIG_N-1:0] addr_hit,
  input  logic [TRIG_N-1:0] data_hit,
  output logic              trap_now,
  output logic              trap_next,
  output logic [IDX_W-1:0]  fire_idx
);

  logic [TRIG_N-1:0]     en_q;
  logic [TRIG_N-1:0]     tim_q;
  logic [TRIG_N-1:0]     dsel_q;
  logic [NUM_GROUPS-1:0] chain_q;
  logic [TRIG_N-1:0]     eff_hit;
  logic [TRIG_N-1:0]     fire_vec;

  dtr_cfg_regs #(
    .NUM_GROUPS (NUM_GROUPS),
    .XLEN       (XLEN),
    .CSR_AW     (CSR_AW),
    .CFG_BASE   (CFG_BASE),
    .CHAIN_ADDR (CHAIN_ADDR)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wen   (csr_wen),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .en_q      (en_q),
    .tim_q     (tim_q),
    .dsel_q    (dsel_q),
    .chain_q   (chain_q)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pair
    dtr_pair_resolve u_pair (
      .en       (en_q[2*g +: 2]),
      .tim      (tim_q[2*g +: 2]),
      .dsel     (dsel_q[2*g +: 2]),
      .addr_hit (addr_hit[2*g +: 2]),
      .data_hit (data_hit[2*g +: 2]),
      .chain    (chain_q[g]),
      .eff_hit  (eff_hit[2*g +: 2]),
      .fire     (fire_vec[2*g +: 2])
    );
  end

  dtr_fire_select #(
    .TRIG_N (TRIG_N)
  ) u_sel (
    .fire_vec  (fire_vec),
    .tim       (tim_q),
    .trap_now  (trap_now),
    .trap_next (trap_next),
    .fire_idx  (fire_idx)
  );

endmodule

// File: rtl/dtr_checker.sv
module dtr_checker #(
  parameter int NUM_GROUPS = 5,
  localparam int TRIG_N    = 2 * NUM_GROUPS,
  localparam int IDX_W     = $clog2(TRIG_N)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csr_wen,
  input logic [TRIG_N-1:0]     en_q,
  input logic [TRIG_N-1:0]     tim_q,
  input logic [NUM_GROUPS-1:0] chain_q,
  input logic [TRIG_N-1:0]     eff_hit,
  input logic [TRIG_N-1:0]     fire_vec,
  input logic                  trap_now,
  input logic                  trap_next,
  input logic [IDX_W-1:0]      fire_idx
);

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec & ~en_q) == '0); // R2

  AST_FIRE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec & ~eff_hit) == '0); // R2

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    AST_CHAIN_BOTH_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      chain_q[g] |-> (fire_vec[2*g] == fire_vec[2*g+1])); // R3

    AST_CHAIN_TIMING_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_q[g] && (tim_q[2*g] != tim_q[2*g+1])) |-> (fire_vec[2*g +: 2] == 2'b00)); // R4
  end

  AST_STORE_PAIR_UNCHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q[1] == 1'b0); // R7

  AST_FLAG_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_now || trap_next) == (fire_vec != '0)); // R5

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec != '0) |-> (fire_vec[fire_idx] &&
      ((fire_vec & ((TRIG_N'(1) << fire_idx) - TRIG_N'(1))) == '0))); // R6

  AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec == '0) |-> (fire_idx == '0)); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_wen) |-> ($stable(en_q) && $stable(tim_q) && $stable(chain_q))); // R9

endmodule

bind dtr_trigger_chain_resolver dtr_checker #(
  .NUM_GROUPS (NUM_GROUPS)
) u_dtr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_wen   (csr_wen),
  .en_q      (en_q),
  .tim_q     (tim_q),
  .chain_q   (chain_q),
  .eff_hit   (eff_hit),
  .fire_vec  (fire_vec),
  .trap_now  (trap_now),
  .trap_next (trap_next),
  .fire_idx  (fire_idx)
);

// File: tb/tb_dtr_trigger_chain_resolver.sv
module tb_dtr_trigger_chain_resolver;

  localparam int NG = 5;
  localparam int TN = 2 * NG;
  localparam int IW = $clog2(TN);
  localparam logic [11:0] BASE  = 12'h7A0;
  localparam logic [11:0] CHADR = 12'h7B0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_wen = 1'b0;
  logic [11:0]   csr_addr = '0;
  logic [63:0]   csr_wdata = '0;
  logic [TN-1:0] addr_hit = '0;
  logic [TN-1:0] data_hit = '0;
  logic          trap_now;
  logic          trap_next;
  logic [IW-1:0] fire_idx;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // bench-side configuration model
  bit m_en[TN];
  bit m_tim[TN];
  bit m_dat[TN];
  bit m_chain[NG];

  always #4 clk = ~clk;

  dtr_trigger_chain_resolver dut (
    .clk (clk), .rst_n (rst_n), .csr_wen (csr_wen), .csr_addr (csr_addr),
    .csr_wdata (csr_wdata), .addr_hit (addr_hit), .data_hit (data_hit),
    .trap_now (trap_now), .trap_next (trap_next), .fire_idx (fire_idx)
  );

  function automatic bit is_load(input int k);
    return (k == 4) || (k == 5) || (k == 9);
  endfunction

  function automatic bit sel_hit(input int k, input logic [TN-1:0] a, input logic [TN-1:0] d);
    if (!m_en[k]) return 0;
    return m_dat[k] ? d[k] : a[k];
  endfunction

  // expected {trap_now, trap_next, idx}
  function automatic logic [IW+1:0] model(input logic [TN-1:0] a, input logic [TN-1:0] d);
    bit now_f = 0;
    bit nxt_f = 0;
    int idx = -1;
    for (int k = 0; k < TN; k++) begin
      int mate = k ^ 1;
      bit f;
      if (m_chain[k/2])
        f = sel_hit(k, a, d) && sel_hit(mate, a, d) && (m_tim[k] == m_tim[mate]);
      else
        f = sel_hit(k, a, d);
      if (f) begin
        if (m_tim[k]) nxt_f = 1; else now_f = 1;
        if (idx < 0) idx = k;
      end
    end
    if (idx < 0) idx = 0;
    return {now_f, nxt_f, IW'(idx)};
  endfunction

  task automatic check(input string req, input logic [IW+1:0] exp_v);
    logic [IW+1:0] got;
    got = {trap_now, trap_next, fire_idx};
    n_checks++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got now=%0b next=%0b idx=%0d expected now=%0b next=%0b idx=%0d",
               req, got[IW+1], got[IW], got[IW-1:0], exp_v[IW+1], exp_v[IW], exp_v[IW-1:0]);
    end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [63:0] d);
    for (int k = 0; k < TN; k++) begin
      if (a == BASE + 12'(k)) begin
        m_en[k]  = d[0];
        m_tim[k] = d[1];
        m_dat[k] = d[2] && !is_load(k);
      end
    end
    if (a == CHADR) begin
      for (int g = 0; g < NG; g++) m_chain[g] = d[g] && (g != 1);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wen = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    csr_wen = 1'b0;
  endtask

  task automatic drive(input logic [TN-1:0] a, input logic [TN-1:0] d);
    @(negedge clk);
    addr_hit = a; data_hit = d;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TN; k++) begin m_en[k] = 0; m_tim[k] = 0; m_dat[k] = 0; end
    for (int g = 0; g < NG; g++) m_chain[g] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state silent under all-ones hits
    drive('1, '1);
    check("R1", {1'b0, 1'b0, IW'(0)});

    // R9: write takes effect only after the write edge
    @(negedge clk);
    addr_hit = 10'b1; data_hit = '0;
    csr_wen = 1'b1; csr_addr = BASE; csr_wdata = 64'h1;
    #1;
    check("R9 before edge", {1'b0, 1'b0, IW'(0)});
    @(posedge clk);
    model_write(BASE, 64'h1);
    #1;
    check("R9 after edge", {1'b1, 1'b0, IW'(0)});
    @(negedge clk);
    csr_wen = 1'b0;

    // R9: unmapped address and high data bits ignored
    csr_write(BASE + 12'd15, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_write(12'h7B1, 64'h1F);
    drive('1, '0);
    check("R9 unmapped", {1'b1, 1'b0, IW'(0)});

    // R2: disabled trigger never fires; enabled unchained fires alone
    drive(10'b10, '0);
    check("R2 disabled", {1'b0, 1'b0, IW'(0)});
    csr_write(BASE + 12'd1, 64'hFFFF_0000_0000_0001);
    drive(10'b10, '0);
    check("R2 unchained", {1'b1, 1'b0, IW'(1)});

    // R3: chained pair needs both halves
    csr_write(CHADR, 64'h01);
    drive(10'b01, '0);
    check("R3 half only", model(10'b01, '0));
    drive(10'b11, '0);
    check("R3 both", {1'b1, 1'b0, IW'(0)});
    // R2: disabled half cannot complete a chain
    csr_write(BASE + 12'd1, 64'h0);
    drive(10'b11, '0);
    check("R2 chain disabled half", {1'b0, 1'b0, IW'(0)});

    // R4: timing mismatch suppresses pair
    csr_write(BASE + 12'd1, 64'h3);
    drive(10'b11, '0);
    check("R4 mismatch", {1'b0, 1'b0, IW'(0)});

    // R7: store-store chain bit cannot be set
    csr_write(CHADR, 64'h1F);
    csr_write(BASE + 12'd2, 64'h1);
    csr_write(BASE + 12'd3, 64'h1);
    drive(10'b0000_0100, '0);
    check("R7 store pair", {1'b1, 1'b0, IW'(2)});
    csr_write(CHADR, 64'h0);

    // R8: load trigger ignores data select, fetch trigger honours it
    csr_write(BASE + 12'd4, 64'h5);
    drive('0, 10'b1_0000);
    check("R8 load data ignored", {1'b0, 1'b0, IW'(0)});
    drive(10'b1_0000, '0);
    check("R8 load addr", {1'b1, 1'b0, IW'(4)});
    csr_write(BASE + 12'd6, 64'h7);
    drive(10'b100_0000, '0);
    check("R8 fetch addr ignored", {1'b0, 1'b0, IW'(0)});
    drive('0, 10'b100_0000);
    check("R8 fetch data", {1'b0, 1'b1, IW'(6)});

    // R5 / R6: both flags and lowest index
    drive(10'b1_0000, 10'b100_0000);
    check("R5 both flags", {1'b1, 1'b1, IW'(4)});
    drive(10'b1_0010, 10'b100_0000);
    check("R6 lowest", {1'b1, 1'b1, IW'(1)});

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 1) == 1) begin
        logic [11:0] a;
        logic [63:0] d;
        case ($urandom_range(0, 3))
          0: a = CHADR;
          1: a = 12'($urandom_range(0, 4095));
          default: a = BASE + 12'($urandom_range(0, 15));
        endcase
        d = {$urandom(), $urandom()};
        csr_write(a, d);
      end
      begin
        logic [TN-1:0] a_h;
        logic [TN-1:0] d_h;
        a_h = TN'($urandom());
        d_h = TN'($urandom());
        drive(a_h, d_h);
        check("R3/R4/R5/R6 random", model(a_h, d_h));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule